// File: doc/BRIEF.md
# Two-Tier Latency DRAM Bank Timing Scheduler

This block models the timing of a single DRAM bank whose rows are split between a short, fast segment and a long, slow segment. Read requests arrive with a row number and are timestamped on entry with the block's own cycle counter. They are queued and served strictly in arrival order under a closed-row policy, so every request opens its row, reads it and precharges it again. Row hits never occur.

A parameter mask fixes which rows sit in the fast segment; every other row is served from the slow segment. The slow segment holds every row, including the fast-mapped ones, but the mask alone picks the timing. For each request the block works out when activation starts. That is the later of the request's own stamp and the end of the previous row's activate-plus-precharge window. Read data follows a segment-dependent delay after activation. The block pulses a data-ready strobe in exactly that cycle, reports the request's latency in cycles, and keeps a running total of latency.

With the default 5 ns cycle, the fast segment reads after 2 cycles and frees the bank after 5 cycles. The slow segment reads after 3 cycles and frees the bank after 10 cycles. The fast read delay must be at least 2 cycles, so that a request can be dequeued before its data is due.

Top module: `tld_bank_sched`

## Requirements
- R1: While reset is held and just after it, dataValid is 0, totalLatency is 0 and reqReady is 1.
- R2: A request to a row whose NEAR_MASK bit is 1, arriving in cycle T with the bank free, gives dataValid in cycle T+NEAR_RD with dataLatency equal to NEAR_RD.
- R3: A request to a row whose NEAR_MASK bit is 0, arriving in cycle T with the bank free, gives dataValid in cycle T+FAR_RD with dataLatency equal to FAR_RD.
- R4: A request arriving while the bank is busy activates when the previous activation's busy window ends, and its latency is that wait plus its own segment's read delay.
- R5: The busy window is set by the previous row's segment: NEAR_BUSY cycles after its activation for a fast row, FAR_BUSY cycles for a slow row.
- R6: Every accepted request yields exactly one dataValid pulse, the pulses come in acceptance order, and no pulse occurs without a pending request.
- R7: The cycle after a dataValid pulse, totalLatency equals the sum of all dataLatency values reported since reset.
- R8: With QUEUE_DEPTH requests waiting, reqReady is 0. A request offered while reqReady is 0 is dropped and produces no pulse. Every accepted request is still served.
- R9: For the stream of rows 0,1,2,1,3,1 at relative cycles 0,2,20,21,40,60, a mask of rows {0,2} totals 115 ns and a mask of rows {1,2} totals 130 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one model time step per cycle |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Read request offered this cycle |
| reqRow | input | ROW_W | Row addressed by the request |
| reqReady | output | 1 | Queue can accept a request this cycle |
| dataValid | output | 1 | Read data of the oldest request is due this cycle |
| dataLatency | output | LAT_W | Cycles from arrival to data for the request being completed |
| totalLatency | output | TOT_W | Running sum of all completed latencies |

## Verification
The bench sweeps every ordered pair of rows at arrival gaps from 1 to 12 cycles. This reaches every combination of prior and current segment both inside and outside the busy window. A design that timed the wait from the current row's segment, rather than the previous one, would return wrong latencies for mixed pairs. A design that compared against the read time instead of the bank-free time would start activations early on short gaps.

A back-to-back burst overfills the queue. An off-by-one in the full flag would either lose an accepted request or strobe for a dropped one. The fixed six-request stream runs against two mappings and must give 115 ns and 130 ns. Those totals only come out right if waiting is charged correctly against the earlier row's window.

// File: rtl/tld_pkg.sv
package tld_pkg;

  typedef struct packed {
    logic pop;   // dequeue the head request and schedule it
    logic emit;  // the scheduled request's data is due now
  } tld_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tld_state_t;

endpackage

// File: rtl/tld_req_fifo.sv
module tld_req_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = pushValid && !full;
  assign doPop  = pop && !empty;
  assign headData = slots[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)
             || (count + 1'b1 == $past(count))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full |=> !(count > CNT_W'(DEPTH))); // R8
endmodule

// File: rtl/tld_bank_ctrl.sv
module tld_bank_ctrl
  import tld_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        queueEmpty,
  input  logic        readDue,
  output tld_strobe_t strobes
);
  tld_state_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strobes.pop  = 1'b0;
    strobes.emit = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!queueEmpty) begin
          strobes.pop = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (readDue) begin
          strobes.emit = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_SINGLE_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emit |=> !strobes.emit); // R6

  AST_POP_THEN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> !strobes.pop); // R6
endmodule

// File: rtl/tld_bank_datapath.sv
module tld_bank_datapath
  import tld_pkg::*;
#(
  parameter int          NUM_ROWS  = 6,
  parameter int          ROW_W     = 3,
  parameter logic [NUM_ROWS-1:0] NEAR_MASK = 6'b000101,
  parameter int          NEAR_RD   = 2,
  parameter int          FAR_RD    = 3,
  parameter int          NEAR_BUSY = 5,
  parameter int          FAR_BUSY  = 10,
  parameter int          TIME_W    = 32,
  parameter int          LAT_W     = 16,
  parameter int          TOT_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  headRow,
  input  logic [TIME_W-1:0] headStamp,
  input  tld_strobe_t       strobes,
  output logic [TIME_W-1:0] nowCnt,
  output logic              readDue,
  output logic [LAT_W-1:0]  dataLatency,
  output logic [TOT_W-1:0]  totalLatency
);
  localparam int MAP_W  = 1 << ROW_W;
  localparam int MIN_RD = (NEAR_RD < FAR_RD) ? NEAR_RD : FAR_RD;

  logic [MAP_W-1:0]  maskPad;
  logic [TIME_W-1:0] rdTab   [MAP_W];
  logic [TIME_W-1:0] busyTab [MAP_W];
  logic [TIME_W-1:0] freeAt, readAt, stampHold, startAt;

  assign maskPad = MAP_W'(NEAR_MASK);

  // Per-row timing lookup, one entry per addressable row
  for (genvar r = 0; r < MAP_W; r++) begin : g_rowTiming
    assign rdTab[r]   = maskPad[r] ? TIME_W'(NEAR_RD)   : TIME_W'(FAR_RD);
    assign busyTab[r] = maskPad[r] ? TIME_W'(NEAR_BUSY) : TIME_W'(FAR_BUSY);
  end

  assign startAt     = (headStamp > freeAt) ? headStamp : freeAt;
  assign readDue     = (nowCnt >= readAt);
  assign dataLatency = LAT_W'(readAt - stampHold);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowCnt       <= '0;
      freeAt       <= '0;
      readAt       <= '0;
      stampHold    <= '0;
      totalLatency <= '0;
    end else begin
      nowCnt <= nowCnt + 1'b1;
      if (strobes.pop) begin
        readAt    <= startAt + rdTab[headRow];
        freeAt    <= startAt + busyTab[headRow];
        stampHold <= headStamp;
      end
      if (strobes.emit) totalLatency <= totalLatency + TOT_W'(dataLatency);
    end
  end

  AST_LAT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emit |-> (dataLatency >= LAT_W'(MIN_RD))); // R4

  AST_READ_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> (readAt < freeAt)); // R5

  AST_FREE_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (freeAt >= $past(freeAt))); // R5

  AST_TOTAL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (totalLatency >= $past(totalLatency))); // R7

  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emit |=> $stable(totalLatency)); // R7
endmodule

// File: rtl/tld_bank_sched.sv
module tld_bank_sched
  import tld_pkg::*;
#(
  parameter int          NUM_ROWS    = 6,
  parameter int          ROW_W       = $clog2(NUM_ROWS),
  parameter logic [NUM_ROWS-1:0] NEAR_MASK = 6'b000101,
  parameter int          NEAR_RD     = 2,
  parameter int          FAR_RD      = 3,
  parameter int          NEAR_BUSY   = 5,
  parameter int          FAR_BUSY    = 10,
  parameter int          QUEUE_DEPTH = 4,
  parameter int          TIME_W      = 32,
  parameter int          LAT_W       = 16,
  parameter int          TOT_W       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [ROW_W-1:0] reqRow,
  output logic             reqReady,
  output logic             dataValid,
  output logic [LAT_W-1:0] dataLatency,
  output logic [TOT_W-1:0] totalLatency
);
  localparam int ENTRY_W = ROW_W + TIME_W;

  tld_strobe_t       strobes;
  logic [TIME_W-1:0] nowCnt;
  logic [ENTRY_W-1:0] headEntry;
  logic              queueEmpty, queueFull, readDue;

  tld_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) queue_i (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(reqValid),
    .pushData ({reqRow, nowCnt}),
    .pop      (strobes.pop),
    .headData (headEntry),
    .empty    (queueEmpty),
    .full     (queueFull)
  );

  tld_bank_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .queueEmpty(queueEmpty),
    .readDue   (readDue),
    .strobes   (strobes)
  );

  tld_bank_datapath #(
    .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W), .NEAR_MASK(NEAR_MASK),
    .NEAR_RD(NEAR_RD), .FAR_RD(FAR_RD),
    .NEAR_BUSY(NEAR_BUSY), .FAR_BUSY(FAR_BUSY),
    .TIME_W(TIME_W), .LAT_W(LAT_W), .TOT_W(TOT_W)
  ) path_i (
    .clk         (clk),
    .rstN        (rstN),
    .headRow     (headEntry[ENTRY_W-1:TIME_W]),
    .headStamp   (headEntry[TIME_W-1:0]),
    .strobes     (strobes),
    .nowCnt      (nowCnt),
    .readDue     (readDue),
    .dataLatency (dataLatency),
    .totalLatency(totalLatency)
  );

  assign reqReady  = !queueFull;
  assign dataValid = strobes.emit;
endmodule

// File: tb/tld_bank_sched_tb_top.sv
module tld_bank_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS_PER_CYC = 5;
  localparam int NEAR_RD = 2, FAR_RD = 3, NEAR_BUSY = 5, FAR_BUSY = 10;
  localparam logic [5:0] MASK_A = 6'b000101;
  localparam logic [5:0] MASK_B = 6'b000110;

  logic        clk = 0, rstN = 0, reqValid = 0;
  logic [2:0]  reqRow = '0;
  logic        reqReady, dataValid, reqReadyB, dataValidB;
  logic [15:0] dataLatency, dataLatencyB;
  logic [31:0] totalLatency, totalLatencyB;

  always #(CLK_PERIOD/2) clk = ~clk;

  tld_bank_sched #(.NEAR_MASK(MASK_A)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRow(reqRow),
    .reqReady(reqReady), .dataValid(dataValid),
    .dataLatency(dataLatency), .totalLatency(totalLatency));

  tld_bank_sched #(.NEAR_MASK(MASK_B)) dutAlt_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRow(reqRow),
    .reqReady(reqReadyB), .dataValid(dataValidB),
    .dataLatency(dataLatencyB), .totalLatency(totalLatencyB));

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= !rstN ? 0 : cyc + 1;

  int    expRead [4096];
  int    expLat  [4096];
  string expTag  [4096];
  int    wrIdx = 0, rdIdx = 0, modelFree = 0, rejected = 0;
  longint sumLat = 0;
  bit    pendTot = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit isNear(input int row);
    return MASK_A[row];
  endfunction

  // Offer one request this cycle; model its timing if accepted
  task automatic issue(input int row);
    int stamp, start;
    @(negedge clk);
    reqValid = 1;
    reqRow   = 3'(row);
    if (reqReady) begin
      stamp = cyc;
      start = (stamp > modelFree) ? stamp : modelFree;
      expRead[wrIdx] = start + (isNear(row) ? NEAR_RD : FAR_RD);
      expLat[wrIdx]  = expRead[wrIdx] - stamp;
      if (start > stamp)   expTag[wrIdx] = "R4 R5";
      else if (isNear(row)) expTag[wrIdx] = "R2";
      else                  expTag[wrIdx] = "R3";
      modelFree = start + (isNear(row) ? NEAR_BUSY : FAR_BUSY);
      wrIdx++;
    end else begin
      rejected++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reqValid = 0;
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (pendTot) begin
        chk(totalLatency == sumLat, "R7", totalLatency, sumLat, "running total");
        pendTot = 0;
      end
      if (dataValid) begin
        if (rdIdx == wrIdx) begin
          chk(0, "R6", 1, 0, "strobe with nothing pending");
        end else begin
          chk(cyc == expRead[rdIdx], {expTag[rdIdx], " R6"}, cyc, expRead[rdIdx], "strobe cycle");
          chk(dataLatency == expLat[rdIdx], expTag[rdIdx], dataLatency, expLat[rdIdx], "latency");
          sumLat += dataLatency;
          pendTot = 1;
          rdIdx++;
        end
      end else if (rdIdx != wrIdx && cyc > expRead[rdIdx]) begin
        chk(0, "R6", cyc, expRead[rdIdx], "missing strobe");
        rdIdx++;
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1, "run did not complete");
    finish_run();
  end

  int refRows [6] = '{0, 1, 2, 1, 3, 1};
  int refAt   [6] = '{0, 2, 20, 21, 40, 60};

  initial begin
    repeat (3) @(negedge clk);
    chk(dataValid == 0, "R1", dataValid, 0, "dataValid in reset");
    chk(totalLatency == 0, "R1", totalLatency, 0, "total in reset");
    chk(reqReady == 1, "R1", reqReady, 1, "ready in reset");
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(dataValid == 0 && reqReady == 1, "R1", {dataValid, reqReady}, 1, "after reset");

    // Reference stream on both mappings
    for (int i = 0; i < 6; i++) begin
      issue(refRows[i]);
      if (i < 5) idle(refAt[i+1] - refAt[i] - 1);
    end
    idle(30);
    chk(totalLatency * NS_PER_CYC == 115, "R9", totalLatency * NS_PER_CYC, 115, "rows 0,2 near total ns");
    chk(totalLatencyB * NS_PER_CYC == 130, "R9", totalLatencyB * NS_PER_CYC, 130, "rows 1,2 near total ns");

    // Pair sweep: every ordered row pair at every short gap
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int g = 1; g <= 12; g++) begin
          issue(a);
          idle(g - 1);
          issue(b);
          idle(25);
        end

    // Burst beyond the queue depth
    begin
      int rejBefore;
      rejBefore = rejected;
      for (int k = 0; k < 12; k++) issue(1);
      idle(1);
      chk(rejected > rejBefore, "R8", rejected - rejBefore, 1, "dropped while full");
      idle(200);
      chk(rdIdx == wrIdx, "R8", rdIdx, wrIdx, "all accepted served");
      chk(reqReady == 1, "R8", reqReady, 1, "ready after drain");
    end

    idle(5);
    finish_run();
  end
endmodule